// File: doc/BRIEF.md
# Packet Receive Checker

This block sits on the receive side of a point-to-point link and checks one packet at a time from a byte-serial stream of 9-bit symbols. Bit 8 of a symbol marks a command; the low eight bits carry either a data byte or a command code. A start command opens a packet. The checker then reads a fixed 8-byte header and reports the operation type, the 20-bit destination and source node IDs, and the payload length. It reads a 4-byte target address next, passes the payload bytes downstream, and compares a trailing 4-byte CRC against its own CRC over the packet.

When each packet ends, the checker gives one verdict as a single-cycle strobe with flags. The flags cover CRC mismatch, an oversized length field, an unknown operation or non-zero reserved bits, and a framing abort. The payload goes out as a registered byte stream with valid and last strobes, so a consumer can start using the data before the CRC verdict arrives.

Top module: `pkt_rx_checker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every output strobe and flag is 0.
- R2: A symbol with bit 8 set is a command and code 0x5C is the start marker. Outside a packet, data symbols and every command except the start marker are ignored and produce no output.
- R3: The header is 8 bytes, most significant byte first. It packs type [63:60], destination [59:40], source [39:20], length [19:13] and reserved [12:0]. One cycle after the eighth header byte, `hdr_valid` pulses and the four fields are presented.
- R4: Operation codes 0 to 3 are defined (0 read request, 1 read response, 2 write request, 3 write response). Any other code, or a non-zero reserved field, sets `type_err` at the end of the packet. The address, the payload and the CRC are still consumed and the payload is still streamed.
- R5: The 4 address bytes follow the header, most significant byte first. `pkt_addr` holds them from the cycle after the last address byte and is still valid when `done` pulses.
- R6: Each payload byte appears on `pay_data` with `pay_valid` one cycle after it is accepted, and `pay_last` marks the final byte. A zero length sends no payload beat and goes straight to the CRC.
- R7: A length field above 64 gives `done` with `len_err` one cycle after the eighth header byte, with no `hdr_valid`. All later symbols up to the next start marker are ignored.
- R8: The CRC is the non-reflected 32-bit CRC with polynomial 0x04C11DB7. It is seeded with all ones, inverted at the end, and taken over the header, address and payload bytes. It is received most significant byte first. One cycle after its fourth byte, `done` pulses with `crc_err` set on a mismatch, and with `good` set only when neither `crc_err` nor `type_err` is set.
- R9: The flow-control command 0x3A inside a packet is ignored and does not disturb the packet.
- R10: Any other command inside a packet gives `done` with `frame_err` one cycle later and drops back to hunting. A start marker inside a packet aborts the packet the same way and opens a new one at once.
- R11: Cycles with `sym_valid` low may fall between any two symbols without changing the result.
- R12: The verdict flags are 0 whenever `done` is low. In a verdict, `good`, `len_err` and `frame_err` exclude each other and every other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A symbol is present this cycle |
| sym_data | input | 9 | Symbol: bit 8 marks a command, bits 7:0 hold the byte or the command code |
| hdr_valid | output | 1 | Header decoded, fields valid |
| hdr_op | output | 4 | Operation type |
| hdr_dst | output | 20 | Destination node ID |
| hdr_src | output | 20 | Source node ID |
| hdr_len | output | 7 | Payload length in bytes |
| pkt_addr | output | 32 | Target address of the current packet |
| pay_valid | output | 1 | Payload byte valid |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte |
| done | output | 1 | End-of-packet verdict strobe |
| good | output | 1 | Packet passed every check |
| crc_err | output | 1 | CRC mismatch |
| len_err | output | 1 | Length field above the cap |
| type_err | output | 1 | Unknown operation or non-zero reserved bits |
| frame_err | output | 1 | Packet aborted by a command |

## Verification
The embedded assertions check these rules on every cycle:
- the flags stay 0 outside a verdict, and one verdict never mixes the exclusive outcomes;
- `pay_last` never appears without `pay_valid`, and payload beats agree with the receive phase;
- no decoded length above the cap is ever reported;
- a flow-control symbol changes neither phase nor count;
- data seen while hunting leaves the checker hunting;
- the CRC register reloads its seed after a start marker.

Only the bench's scenarios can show the values themselves:
- the header fields, the address and the payload bytes against what was sent;
- the CRC verdict for a packet that is intact and for one that is corrupted;
- the exact cycle each verdict appears for the length, type and abort cases;
- that a packet still checks out after idle gaps, flow symbols and stray bytes.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int SYM_W      = 9;
  localparam int BYTE_W     = 8;
  localparam int OP_W       = 4;
  localparam int ID_W       = 20;
  localparam int LEN_W      = 7;
  localparam int RSV_W      = 13;
  localparam int HDR_W      = OP_W + 2 * ID_W + LEN_W + RSV_W;
  localparam int HDR_BYTES  = HDR_W / BYTE_W;
  localparam int ADDR_BYTES = 4;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int CRC_BYTES  = 4;
  localparam int CRC_W      = CRC_BYTES * BYTE_W;
  localparam int CNT_W      = LEN_W;

  localparam logic [BYTE_W-1:0] CMD_START = 8'h5C;
  localparam logic [BYTE_W-1:0] CMD_FLOW  = 8'h3A;

  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  localparam logic [OP_W-1:0] OP_RD_REQ = 4'd0;
  localparam logic [OP_W-1:0] OP_RD_RSP = 4'd1;
  localparam logic [OP_W-1:0] OP_WR_REQ = 4'd2;
  localparam logic [OP_W-1:0] OP_WR_RSP = 4'd3;

  typedef enum logic [2:0] {
    ST_HUNT, ST_HDR, ST_ADDR, ST_PAY, ST_CRC
  } rx_phase_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [ID_W-1:0]  dst;
    logic [ID_W-1:0]  src;
    logic [LEN_W-1:0] len;
    logic [RSV_W-1:0] rsv;
  } pkt_hdr_t;

  // One byte through the CRC register, high bit of the byte first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic [BYTE_W-1:0] din);
    logic [CRC_W-1:0] acc;
    acc = cur;
    for (int k = BYTE_W - 1; k >= 0; k--) begin
      if (acc[CRC_W-1] ^ din[k]) acc = (acc << 1) ^ CRC_POLY;
      else                       acc = acc << 1;
    end
    return acc;
  endfunction

  function automatic logic op_defined(input logic [OP_W-1:0] op);
    return (op == OP_RD_REQ) || (op == OP_RD_RSP) ||
           (op == OP_WR_REQ) || (op == OP_WR_RSP);
  endfunction
endpackage

// File: rtl/pkt_crc_unit.sv
module pkt_crc_unit
  import pkt_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);
  logic [CRC_W-1:0] crc_nxt;

  always_comb crc_nxt = crc_step(crc_q, din);

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_SEED;
    else if (clear) crc_q <= CRC_SEED;
    else if (en)    crc_q <= crc_nxt;
  end

  // R8: a start marker always restarts the running CRC from its seed
  a_r8_seed_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> crc_q == CRC_SEED);
endmodule

// File: rtl/pkt_hdr_decode.sv
module pkt_hdr_decode
  import pkt_rx_pkg::*;
#(
  parameter int PAY_MAX = 64
) (
  input  logic [HDR_W-1:0] raw,
  output pkt_hdr_t         hdr,
  output logic             too_long,
  output logic             bad_fmt
);
  always_comb begin
    hdr      = pkt_hdr_t'(raw);
    too_long = int'(hdr.len) > PAY_MAX;
    bad_fmt  = !op_defined(hdr.op) || (hdr.rsv != '0);
  end
endmodule

// File: rtl/pkt_rx_checker.sv
module pkt_rx_checker
  import pkt_rx_pkg::*;
#(
  parameter int PAY_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic [SYM_W-1:0]  sym_data,
  output logic              hdr_valid,
  output logic [OP_W-1:0]   hdr_op,
  output logic [ID_W-1:0]   hdr_dst,
  output logic [ID_W-1:0]   hdr_src,
  output logic [LEN_W-1:0]  hdr_len,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic              pay_valid,
  output logic [BYTE_W-1:0] pay_data,
  output logic              pay_last,
  output logic              done,
  output logic              good,
  output logic              crc_err,
  output logic              len_err,
  output logic              type_err,
  output logic              frame_err
);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_BYTES - 1);

  // Symbol classification, brought out for the assertions.
  logic              is_cmd, is_dat, saw_start, saw_flow, saw_abort;
  logic [BYTE_W-1:0] sym_byte;

  rx_phase_e         phase;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-BYTE_W-1:0]  hdr_sr;
  logic [ADDR_W-BYTE_W-1:0] addr_sr;
  logic [CRC_W-BYTE_W-1:0]  rcrc_sr;
  logic [LEN_W-1:0]  len_q;
  logic              fmt_bad_q;

  logic [HDR_W-1:0]  hdr_word;
  pkt_hdr_t          hdr_dec;
  logic              dec_too_long, dec_bad_fmt;

  logic              crc_clear, crc_en;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  rx_crc_word;
  logic              crc_match;

  always_comb begin
    sym_byte  = sym_data[BYTE_W-1:0];
    is_cmd    = sym_valid && sym_data[SYM_W-1];
    is_dat    = sym_valid && !sym_data[SYM_W-1];
    saw_start = is_cmd && (sym_byte == CMD_START);
    saw_flow  = is_cmd && (sym_byte == CMD_FLOW);
    saw_abort = is_cmd && !saw_flow && !saw_start && (phase != ST_HUNT);
  end

  always_comb begin
    hdr_word    = {hdr_sr, sym_byte};
    rx_crc_word = {rcrc_sr, sym_byte};
    crc_match   = (~crc_q) == rx_crc_word;
    crc_clear   = saw_start;
    crc_en      = is_dat && (phase == ST_HDR || phase == ST_ADDR || phase == ST_PAY);
  end

  pkt_hdr_decode #(.PAY_MAX(PAY_MAX)) u_dec (
    .raw      (hdr_word),
    .hdr      (hdr_dec),
    .too_long (dec_too_long),
    .bad_fmt  (dec_bad_fmt)
  );

  pkt_crc_unit u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (crc_clear),
    .en    (crc_en),
    .din   (sym_byte),
    .crc_q (crc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= ST_HUNT;
      cnt       <= '0;
      hdr_sr    <= '0;
      addr_sr   <= '0;
      rcrc_sr   <= '0;
      len_q     <= '0;
      fmt_bad_q <= 1'b0;
      hdr_valid <= 1'b0;
      hdr_op    <= '0;
      hdr_dst   <= '0;
      hdr_src   <= '0;
      hdr_len   <= '0;
      pkt_addr  <= '0;
      pay_valid <= 1'b0;
      pay_data  <= '0;
      pay_last  <= 1'b0;
      done      <= 1'b0;
      good      <= 1'b0;
      crc_err   <= 1'b0;
      len_err   <= 1'b0;
      type_err  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      hdr_valid <= 1'b0;
      pay_valid <= 1'b0;
      pay_last  <= 1'b0;
      done      <= 1'b0;
      good      <= 1'b0;
      crc_err   <= 1'b0;
      len_err   <= 1'b0;
      type_err  <= 1'b0;
      frame_err <= 1'b0;
      if (saw_start) begin
        if (phase != ST_HUNT) begin
          done      <= 1'b1;
          frame_err <= 1'b1;
        end
        phase     <= ST_HDR;
        cnt       <= '0;
        fmt_bad_q <= 1'b0;
      end else if (saw_abort) begin
        done      <= 1'b1;
        frame_err <= 1'b1;
        phase     <= ST_HUNT;
        cnt       <= '0;
      end else if (is_dat) begin
        unique case (phase)
          ST_HDR: begin
            hdr_sr <= hdr_word[HDR_W-BYTE_W-1:0];
            cnt    <= cnt + 1'b1;
            if (cnt == HDR_LAST) begin
              cnt <= '0;
              if (dec_too_long) begin
                done    <= 1'b1;
                len_err <= 1'b1;
                phase   <= ST_HUNT;
              end else begin
                hdr_valid <= 1'b1;
                hdr_op    <= hdr_dec.op;
                hdr_dst   <= hdr_dec.dst;
                hdr_src   <= hdr_dec.src;
                hdr_len   <= hdr_dec.len;
                len_q     <= hdr_dec.len;
                fmt_bad_q <= dec_bad_fmt;
                phase     <= ST_ADDR;
              end
            end
          end
          ST_ADDR: begin
            addr_sr <= {addr_sr[ADDR_W-2*BYTE_W-1:0], sym_byte};
            cnt     <= cnt + 1'b1;
            if (cnt == ADDR_LAST) begin
              pkt_addr <= {addr_sr, sym_byte};
              cnt      <= '0;
              phase    <= (len_q == '0) ? ST_CRC : ST_PAY;
            end
          end
          ST_PAY: begin
            pay_valid <= 1'b1;
            pay_data  <= sym_byte;
            cnt       <= cnt + 1'b1;
            if (cnt == len_q - 1'b1) begin
              pay_last <= 1'b1;
              cnt      <= '0;
              phase    <= ST_CRC;
            end
          end
          ST_CRC: begin
            rcrc_sr <= rx_crc_word[CRC_W-BYTE_W-1:0];
            cnt     <= cnt + 1'b1;
            if (cnt == CRC_LAST) begin
              done     <= 1'b1;
              crc_err  <= !crc_match;
              type_err <= fmt_bad_q;
              good     <= crc_match && !fmt_bad_q;
              cnt      <= '0;
              phase    <= ST_HUNT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: verdict flags only ever appear together with the done strobe
  a_r12_flags_need_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(good || crc_err || len_err || type_err || frame_err));
  // R12: a verdict carries exactly one kind of outcome
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({good, crc_err || type_err, len_err, frame_err}));
  // R6: the last marker is part of a payload beat
  a_r6_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
    pay_last |-> pay_valid);
  // R6: a non-final beat leaves the checker in the payload phase, a final one in the CRC phase
  a_r6_beat_phase: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> (pay_last ? (phase == ST_CRC) : (phase == ST_PAY)));
  // R7: no decoded length above the cap is ever presented
  a_r7_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> int'(hdr_len) <= PAY_MAX);
  // R9: a flow-control symbol inside a packet changes nothing
  a_r9_flow_neutral: assert property (@(posedge clk) disable iff (!rst_n)
    (saw_flow && phase != ST_HUNT) |=> (phase == $past(phase)) && $stable(cnt) && !done);
  // R2: data seen while hunting never leaves the hunting phase
  a_r2_hunt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_HUNT && is_dat) |=> phase == ST_HUNT && !pay_valid && !done);
endmodule

// File: tb/pkt_rx_checker_tb.sv
module pkt_rx_checker_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [8:0] sym_data = '0;
  logic       hdr_valid, pay_valid, pay_last, done;
  logic       good, crc_err, len_err, type_err, frame_err;
  logic [3:0] hdr_op;
  logic [19:0] hdr_dst, hdr_src;
  logic [6:0] hdr_len;
  logic [31:0] pkt_addr;
  logic [7:0] pay_data;

  localparam logic [8:0] SYM_START = 9'h15C;
  localparam logic [8:0] SYM_FLOW  = 9'h13A;
  localparam logic [8:0] SYM_OTHER = 9'h111;

  int n_checks = 0;
  int n_fail   = 0;
  int stray    = 0;
  bit flag_leak = 1'b0;
  int cycles   = 0;

  logic [8:0]  exp_pay[$];
  logic [50:0] exp_hdr[$];
  string       hdr_tag[$];
  logic [37:0] exp_done[$];
  string       done_tag[$];

  always #5 clk = ~clk;

  pkt_rx_checker u_dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
    .hdr_valid(hdr_valid), .hdr_op(hdr_op), .hdr_dst(hdr_dst), .hdr_src(hdr_src),
    .hdr_len(hdr_len), .pkt_addr(pkt_addr), .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_last(pay_last), .done(done), .good(good), .crc_err(crc_err),
    .len_err(len_err), .type_err(type_err), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Reference CRC: shift the message through bit by bit, high bit first.
  function automatic logic [31:0] ref_crc(input logic [7:0] m [0:95], input int len);
    logic [31:0] c;
    logic top;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++)
      for (int j = 7; j >= 0; j--) begin
        top = c[31];
        c = {c[30:0], 1'b0};
        if (top != m[i][j]) c = c ^ 32'h04C11DB7;
      end
    return ~c;
  endfunction

  task automatic send_sym(input logic [8:0] s);
    @(negedge clk);
    sym_valid = 1'b1;
    sym_data  = s;
  endtask

  task automatic idle(input int k);
    repeat (k) begin
      @(negedge clk);
      sym_valid = 1'b0;
      sym_data  = 9'h0AA;
    end
  endtask

  // Driver: builds a packet, pushes what the checker should produce, then sends it.
  task automatic send_pkt(input logic [3:0] typ, input logic [19:0] dst, input logic [19:0] src,
                          input logic [6:0] len, input logic [12:0] rsv, input logic [31:0] ad,
                          input logic [7:0] seed, input bit bad_crc, input bit gaps,
                          input int abort_at, input logic [8:0] abort_sym, input bit no_start,
                          input string tag);
    logic [7:0] b [0:95];
    logic [63:0] h;
    logic [31:0] c;
    int n;
    bit over, fbad;
    for (int i = 0; i < 96; i++) b[i] = 8'h00;
    h = {typ, dst, src, len, rsv};
    for (int i = 0; i < 8; i++) b[i] = h[63-8*i -: 8];
    for (int i = 0; i < 4; i++) b[8+i] = ad[31-8*i -: 8];
    over = len > 7'd64;
    fbad = (typ > 4'd3) || (rsv != 13'd0);
    if (over) begin
      n = 28;
      for (int i = 8; i < n; i++) b[i] = seed + 8'(i);
    end else begin
      for (int i = 0; i < int'(len); i++) b[12+i] = seed + 8'(i * 37);
      c = ref_crc(b, 12 + int'(len));
      if (bad_crc) c = c ^ 32'h0000_0100;
      for (int i = 0; i < 4; i++) b[12+int'(len)+i] = c[31-8*i -: 8];
      n = 16 + int'(len);
    end
    if (abort_at >= 0) begin
      if (abort_at >= 8 && !over) begin
        exp_hdr.push_back({typ, dst, src, len});
        hdr_tag.push_back({tag, " header before abort"});
      end
      for (int i = 12; i < 12 + int'(len) && !over; i++)
        if (i < abort_at) exp_pay.push_back({i == 11 + int'(len), b[i]});
      exp_done.push_back({1'b0, 32'h0, 5'b00001});
      done_tag.push_back({tag, " R10 abort verdict"});
    end else if (over) begin
      exp_done.push_back({1'b0, 32'h0, 5'b00100});
      done_tag.push_back({tag, " R7 length verdict"});
    end else begin
      exp_hdr.push_back({typ, dst, src, len});
      hdr_tag.push_back({tag, " R3 header fields"});
      for (int i = 0; i < int'(len); i++)
        exp_pay.push_back({i == int'(len) - 1, b[12+i]});
      exp_done.push_back({1'b1, ad, !bad_crc && !fbad, bad_crc, 1'b0, fbad, 1'b0});
      done_tag.push_back({tag, " R8 verdict and R5 address"});
    end
    if (!no_start) send_sym(SYM_START);
    for (int i = 0; i < n; i++) begin
      if (i == abort_at) begin
        send_sym(abort_sym);
        break;
      end
      if (gaps && (i % 3 == 1)) begin
        send_sym(SYM_FLOW);
        idle(2);
      end
      send_sym({1'b0, b[i]});
    end
    idle(3);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pay_valid) begin
        if (exp_pay.size() == 0) begin
          stray++;
          chk(1'b0, "R6 unexpected payload beat", {55'h0, pay_last, pay_data}, 64'h0);
        end else begin
          logic [8:0] e;
          e = exp_pay.pop_front();
          chk({pay_last, pay_data} == e, "R6 payload beat", {55'h0, pay_last, pay_data}, {55'h0, e});
        end
      end
      if (hdr_valid) begin
        if (exp_hdr.size() == 0) begin
          stray++;
          chk(1'b0, "R3 unexpected header", 64'h1, 64'h0);
        end else begin
          logic [50:0] e;
          string t;
          e = exp_hdr.pop_front();
          t = hdr_tag.pop_front();
          chk({hdr_op, hdr_dst, hdr_src, hdr_len} == e, t,
              {13'h0, hdr_op, hdr_dst, hdr_src, hdr_len}, {13'h0, e});
        end
      end
      if (done) begin
        if (exp_done.size() == 0) begin
          stray++;
          chk(1'b0, "R8 unexpected verdict", 64'h1, 64'h0);
        end else begin
          logic [37:0] e;
          string t;
          logic [4:0] f;
          e = exp_done.pop_front();
          t = done_tag.pop_front();
          f = {good, crc_err, len_err, type_err, frame_err};
          chk(f == e[4:0], t, {59'h0, f}, {59'h0, e[4:0]});
          if (e[37]) chk(pkt_addr == e[36:5], {t, " R5 address"}, {32'h0, pkt_addr}, {32'h0, e[36:5]});
        end
      end else if (good || crc_err || len_err || type_err || frame_err) begin
        flag_leak = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog expired", 64'h0, 64'h1);
      finish_run();
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    chk({hdr_valid, pay_valid, pay_last, done, good, crc_err, len_err, type_err, frame_err} == 9'h0,
        "R1 reset state", {55'h0, hdr_valid, pay_valid, pay_last, done, good, crc_err, len_err, type_err, frame_err}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hdr_valid, pay_valid, done} == 3'b0, "R1 first cycle after reset",
        {61'h0, hdr_valid, pay_valid, done}, 64'h0);

    // R2: stray bytes and commands while hunting
    s0 = stray;
    send_sym(9'h012); send_sym(9'h0FF); send_sym(SYM_OTHER); send_sym(SYM_FLOW); send_sym(9'h033);
    idle(4);
    chk(stray == s0, "R2 idle symbols ignored", 64'(stray), 64'(s0));

    // Zero-length read response (R6 zero-length, R8 good)
    send_pkt(4'd1, 20'hABCDE, 20'h12345, 7'd0, 13'd0, 32'hDEAD_BEEF, 8'h00, 0, 0, -1, 9'h0, 0, "zero-len");
    // Full 64-byte write request
    send_pkt(4'd2, 20'h00001, 20'hFFFFF, 7'd64, 13'd0, 32'h0000_1000, 8'h5A, 0, 0, -1, 9'h0, 0, "max-len");
    // Corrupted CRC
    send_pkt(4'd0, 20'h11111, 20'h22222, 7'd5, 13'd0, 32'h8000_0001, 8'h10, 1, 0, -1, 9'h0, 0, "R8 bad crc");
    // R4: unknown type, payload still streamed
    send_pkt(4'd9, 20'h33333, 20'h44444, 7'd3, 13'd0, 32'h0000_00FF, 8'h20, 0, 0, -1, 9'h0, 0, "R4 bad type");
    // R4: reserved bits set
    send_pkt(4'd3, 20'h55555, 20'h66666, 7'd1, 13'h0040, 32'h1234_5678, 8'h30, 0, 0, -1, 9'h0, 0, "R4 reserved");
    // R7: oversized length, trailing bytes must be ignored
    s0 = stray;
    send_pkt(4'd2, 20'h77777, 20'h88888, 7'd65, 13'd0, 32'h0, 8'h40, 0, 0, -1, 9'h0, 0, "R7 overrun");
    chk(stray == s0, "R7 bytes after length error ignored", 64'(stray), 64'(s0));
    // R9 / R11: flow symbols and idle gaps inside a good packet
    send_pkt(4'd2, 20'h9ABCD, 20'h0F0F0, 7'd10, 13'd0, 32'hCAFE_F00D, 8'h77, 0, 1, -1, 9'h0, 0, "R9 R11 gaps");
    // R10: other command mid-payload
    send_pkt(4'd2, 20'h01020, 20'h03040, 7'd8, 13'd0, 32'h0, 8'h90, 0, 0, 15, SYM_OTHER, 0, "R10 cmd");
    // R10: start marker mid-header, then the new packet continues without its own start
    send_pkt(4'd0, 20'h0AAAA, 20'h0BBBB, 7'd4, 13'd0, 32'h0, 8'h01, 0, 0, 5, SYM_START, 0, "R10 restart");
    send_pkt(4'd1, 20'h0CCCC, 20'h0DDDD, 7'd2, 13'd0, 32'h0BAD_CAFE, 8'hE0, 0, 0, -1, 9'h0, 1, "R10 new pkt");
    // A good packet after all the errors
    send_pkt(4'd0, 20'hFEDCB, 20'h13579, 7'd1, 13'd0, 32'hFFFF_FFFF, 8'hC3, 0, 0, -1, 9'h0, 0, "recovery");

    idle(10);
    chk(exp_pay.size() == 0 && exp_hdr.size() == 0 && exp_done.size() == 0,
        "R8 every expected output seen", 64'(exp_pay.size() + exp_hdr.size() + exp_done.size()), 64'h0);
    chk(!flag_leak, "R12 flags only with done", {63'h0, flag_leak}, 64'h0);
    finish_run();
  end
endmodule